// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Receive Framer

This block turns an asynchronous serial line into received characters. An external 16x oversampling tick paces it. While the block is idle, a low level on the line starts a possible frame. The block confirms the start bit half a bit later and then samples each following bit at its centre. One 10-bit word per character leaves the block with a single-cycle valid strobe. The data sits in the low bits, a parity-error flag in bit 8 and a framing-error flag in bit 9. A separate flag marks characters that are breaks.

A 3-bit format code selects the frame shape. The shapes are plain 8-bit, 7-bit plus parity, 8-bit plus parity, 9-bit, and 8-bit plus a wake-up bit. A 2-bit stop code selects half, one, one-and-a-half or two stop bits. A parity-sense input chooses odd or even parity. A loopback input makes the receiver listen to the local transmit line in place of the external pin. A receive-enable input decides whether new frames may start. The selected line passes through a two-flop synchroniser before any sampling. Word storage, baud generation and register access belong to the surrounding design.

Top module: `serial_rx_framer`

## Requirements
- R1: While reset is high, and after it, until a frame completes: rx_valid = 0, rx_break = 0 and rx_word = 0.
- R2: A start is taken only if the line is still low 8 ticks after it was first seen low. A low pulse shorter than half a bit produces no word.
- R3: fmt_mode 001, and the unlisted codes 000, 010 and 110, receive 8 data bits, LSB first, into rx_word[7:0]. In these formats rx_word[8] = 0.
- R4: fmt_mode 011 receives 7 data bits into rx_word[6:0], with rx_word[7] = 0. A parity bit follows the data, and its check result appears at rx_word[8].
- R5: fmt_mode 111 receives 8 data bits into rx_word[7:0]. A parity bit follows the data, and its check result appears at rx_word[8].
- R6: fmt_mode 100 (9 data bits) and 101 (8 data bits plus wake-up bit) receive nine bits into rx_word[8:0], with no parity check.
- R7: With par_odd = 1 the data bits plus the parity bit must hold an odd number of ones. With par_odd = 0 they must hold an even number. rx_word[8] is set when the rule is broken.
- R8: rx_word[9] is set when the centre sample of the first stop bit is low. With stop_sel 11 it is also set when the centre sample of the second stop bit is low.
- R9: stop_sel 00/01/10/11 sets a stop length of 0.5/1/1.5/2 bits. A new start bit that follows immediately after the configured stop length is received.
- R10: rx_break goes high with rx_valid exactly when rx_word[9] is set and every data bit of the format is zero.
- R11: With loop_en = 1 the receiver decodes tx_line, and rx_pin has no effect.
- R12: With rx_en = 0 no new frame starts, and the line produces no word.
- R13: rx_valid is a one-cycle pulse per character, and rx_break is never high without rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | 16x oversampling enable, one cycle per tick |
| rx_pin | input | 1 | External serial input |
| tx_line | input | 1 | Local transmit line, used in loopback |
| loop_en | input | 1 | Selects tx_line as the receive source |
| rx_en | input | 1 | Allows new frames to start |
| fmt_mode | input | 3 | Frame format code |
| stop_sel | input | 2 | Stop length code |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_word | output | 10 | {frame error, parity error or ninth bit, data} |
| rx_valid | output | 1 | Word strobe |
| rx_break | output | 1 | Received character is a break |

## Verification
Directed frames in every format show where each format puts its bits and flags. They separate the 7-bit layout from the 8-bit parity layout and from the 9-bit layout, and they show a parity error under both parity senses. Back-to-back frames at each stop length check that the receiver is idle again exactly when the next start bit arrives. Corrupted stop bits, including the second of two stop bits, and an all-low character separate a framing error from a break. Short low glitches, a disabled receiver and a loopback run with the pin held low must produce no extra words. Constrained-random frames then mix formats, stop lengths, parity senses, gaps and injected errors, and each word is compared with a model of the line.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int TW = 8;   // tick counter width
  localparam int DW = 9;   // widest captured field
  localparam int WW = 10;  // output word width

  localparam logic [2:0] MODE_8N = 3'b001;
  localparam logic [2:0] MODE_7P = 3'b011;
  localparam logic [2:0] MODE_9N = 3'b100;
  localparam logic [2:0] MODE_8W = 3'b101;
  localparam logic [2:0] MODE_8P = 3'b111;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxf_state_e;

  typedef struct packed {
    logic [3:0]    nbits;    // bits after the start bit, parity included
    logic          has_par;
    logic [DW-1:0] dmask;    // data bits reported
    logic [DW-1:0] umask;    // bits that enter the parity sum
  } rxf_fmt_t;

  typedef struct packed {
    logic [TW-1:0] s1;       // tick of first stop sample
    logic          two;      // sample the second stop bit too
    logic [TW-1:0] emit;     // tick the word is issued
    logic [TW-1:0] idle_at;  // tick the framer re-arms
  } rxf_stop_t;
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic loop_i,
  input  logic loop_en,
  output logic line_o
);
  logic [STAGES-1:0] ff_q;
  logic src;

  assign src = loop_en ? loop_i : pin_i;

  always_ff @(posedge clk) begin
    if (rst) ff_q[0] <= 1'b1;
    else     ff_q[0] <= src;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) ff_q[g] <= 1'b1;
      else     ff_q[g] <= ff_q[g-1];
    end
  end

  assign line_o = ff_q[STAGES-1];
endmodule

// File: rtl/rxf_fmt.sv
module rxf_fmt
  import rxf_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic [2:0] mode_i,
  input  logic [1:0] stop_i,
  output rxf_fmt_t   fmt_o,
  output rxf_stop_t  stp_o
);
  localparam int HALF = OVS / 2;
  localparam int QTR3 = (OVS * 3) / 4;

  always_comb begin
    case (mode_i)
      MODE_7P: fmt_o = '{nbits: 4'd8, has_par: 1'b1, dmask: 9'h07F, umask: 9'h0FF};
      MODE_8P: fmt_o = '{nbits: 4'd9, has_par: 1'b1, dmask: 9'h0FF, umask: 9'h1FF};
      MODE_9N,
      MODE_8W: fmt_o = '{nbits: 4'd9, has_par: 1'b0, dmask: 9'h1FF, umask: 9'h1FF};
      default: fmt_o = '{nbits: 4'd8, has_par: 1'b0, dmask: 9'h0FF, umask: 9'h0FF};
    endcase
  end

  always_comb begin
    case (stop_i)
      2'b00:   stp_o = '{s1: TW'(QTR3), two: 1'b0, emit: TW'(QTR3), idle_at: TW'(OVS - 1)};
      2'b01:   stp_o = '{s1: TW'(OVS), two: 1'b0, emit: TW'(OVS), idle_at: TW'(OVS + HALF - 1)};
      2'b10:   stp_o = '{s1: TW'(OVS), two: 1'b0, emit: TW'(OVS), idle_at: TW'(2 * OVS - 1)};
      default: stp_o = '{s1: TW'(OVS), two: 1'b1, emit: TW'(2 * OVS), idle_at: TW'(2 * OVS + HALF - 1)};
    endcase
  end
endmodule

// File: rtl/rxf_core.sv
module rxf_core
  import rxf_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic          rx_en,
  input  logic          par_odd,
  input  rxf_fmt_t      fmt_i,
  input  rxf_stop_t     stp_i,
  output logic [WW-1:0] word_o,
  output logic          valid_o,
  output logic          brk_o
);
  localparam logic [TW-1:0] HALF_T = TW'(OVS / 2);
  localparam logic [TW-1:0] BIT_T  = TW'(OVS);
  localparam logic [TW-1:0] MID2_T = TW'(2 * OVS);

  rxf_state_e    st_q;
  logic [TW-1:0] cnt_q, cnt_nx;
  logic [3:0]    idx_q;
  logic [DW-1:0] sh_q, used, dat;
  logic          fe_q, fe_now, pe;
  logic [WW-1:0] word_nx;

  always_comb begin
    cnt_nx  = cnt_q + 1'b1;
    used    = sh_q & fmt_i.umask;
    dat     = sh_q & fmt_i.dmask;
    pe      = fmt_i.has_par & ((^used) ^ par_odd);
    fe_now  = fe_q
            | ((cnt_nx == stp_i.s1) & ~line_i)
            | (stp_i.two & (cnt_nx == MID2_T) & ~line_i);
    word_nx = {fe_now, (fmt_i.has_par ? pe : dat[8]), dat[7:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      fe_q    <= 1'b0;
      word_o  <= '0;
      valid_o <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      brk_o   <= 1'b0;
      if (tick_i) begin
        case (st_q)
          ST_IDLE: begin
            if (!line_i && rx_en) begin
              st_q  <= ST_START;
              cnt_q <= '0;
              idx_q <= '0;
              sh_q  <= '0;
              fe_q  <= 1'b0;
            end
          end
          ST_START: begin
            cnt_q <= cnt_nx;
            if (cnt_nx == HALF_T) begin
              cnt_q <= '0;
              st_q  <= line_i ? ST_IDLE : ST_DATA;
            end
          end
          ST_DATA: begin
            cnt_q <= cnt_nx;
            if (cnt_nx == BIT_T) begin
              cnt_q       <= '0;
              sh_q[idx_q] <= line_i;
              if (idx_q == fmt_i.nbits - 4'd1) st_q <= ST_STOP;
              else                             idx_q <= idx_q + 4'd1;
            end
          end
          default: begin
            cnt_q <= cnt_nx;
            fe_q  <= fe_now;
            if (cnt_nx == stp_i.emit) begin
              word_o  <= word_nx;
              valid_o <= 1'b1;
              brk_o   <= fe_now && (dat == '0);
            end
            if (cnt_nx >= stp_i.idle_at) st_q <= ST_IDLE;
          end
        endcase
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R13
  AST_BREAK_WITH_FE: assert property (@(posedge clk) disable iff (rst)
    brk_o |-> (valid_o && word_o[9])); // R10
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_START && $past(st_q) == ST_IDLE) |-> $past(rx_en)); // R12
  AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_START && tick_i && cnt_nx == HALF_T && line_i) |=> (st_q == ST_IDLE)); // R2
  AST_PLAIN_NO_PE: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !$past(fmt_i.has_par) && !$past(fmt_i.dmask[8])) |-> !word_o[8]); // R3
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import rxf_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          rx_pin,
  input  logic          tx_line,
  input  logic          loop_en,
  input  logic          rx_en,
  input  logic [2:0]    fmt_mode,
  input  logic [1:0]    stop_sel,
  input  logic          par_odd,
  output logic [WW-1:0] rx_word,
  output logic          rx_valid,
  output logic          rx_break
);
  logic      line;
  rxf_fmt_t  fmt;
  rxf_stop_t stp;

  rxf_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .pin_i(rx_pin), .loop_i(tx_line),
    .loop_en(loop_en), .line_o(line)
  );

  rxf_fmt #(.OVS(OVS)) i_fmt (
    .mode_i(fmt_mode), .stop_i(stop_sel), .fmt_o(fmt), .stp_o(stp)
  );

  rxf_core #(.OVS(OVS)) i_core (
    .clk(clk), .rst(rst), .tick_i(os_tick), .line_i(line), .rx_en(rx_en),
    .par_odd(par_odd), .fmt_i(fmt), .stp_i(stp),
    .word_o(rx_word), .valid_o(rx_valid), .brk_o(rx_break)
  );
endmodule

// File: tb/test_serial_rx_framer.sv
`timescale 1ns/1ps
module test_serial_rx_framer;
  logic clk = 1'b0, rst = 1'b1, os_tick = 1'b0;
  logic rx_pin = 1'b1, tx_line = 1'b1, loop_en = 1'b0, rx_en = 1'b1;
  logic [2:0] fmt_mode = 3'b001;
  logic [1:0] stop_sel = 2'b01;
  logic par_odd = 1'b0;
  logic [9:0] rx_word;
  logic rx_valid, rx_break;

  int n_chk = 0, n_fail = 0, n_valid = 0;
  logic [10:0] eq[$];
  string tq[$];
  logic prev_v = 1'b0;
  bit finished = 1'b0;
  logic [2:0] modes [5] = '{3'b001, 3'b011, 3'b100, 3'b101, 3'b111};

  serial_rx_framer i_serial_rx_framer (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_pin(rx_pin), .tx_line(tx_line),
    .loop_en(loop_en), .rx_en(rx_en), .fmt_mode(fmt_mode), .stop_sel(stop_sel),
    .par_odd(par_odd), .rx_word(rx_word), .rx_valid(rx_valid), .rx_break(rx_break)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) os_tick <= rst ? 1'b0 : ~os_tick;

  function automatic int nbits(input logic [2:0] m);
    return (m == 3'b100 || m == 3'b101 || m == 3'b111) ? 9 : 8;
  endfunction
  function automatic bit is_par(input logic [2:0] m);
    return (m == 3'b011 || m == 3'b111);
  endfunction
  function automatic logic [8:0] dmask(input logic [2:0] m);
    if (m == 3'b011) return 9'h07F;
    if (m == 3'b100 || m == 3'b101) return 9'h1FF;
    return 9'h0FF;
  endfunction
  function automatic logic [10:0] model(input logic [2:0] m, input logic [8:0] d,
                                        input bit bp, input bit fe);
    logic [8:0] dd;
    logic [9:0] w;
    dd = d & dmask(m);
    w = {fe, (is_par(m) ? bp : dd[8]), dd[7:0]};
    return {(fe && dd == 9'd0), w};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (2 * n) @(negedge clk);
  endtask
  task automatic put(input logic v);
    if (loop_en) tx_line = v; else rx_pin = v;
  endtask
  task automatic cfg(input logic [2:0] m, input logic [1:0] s, input logic po);
    fmt_mode = m; stop_sel = s; par_odd = po;
    tk(4);
  endtask

  task automatic send(input logic [8:0] d, input bit bp, input bit bs, input bit bs2);
    int nb, st, seg;
    nb = nbits(fmt_mode);
    put(1'b0); tk(16);
    for (int i = 0; i < nb; i++) begin
      if (is_par(fmt_mode) && i == nb - 1)
        put((^(d & dmask(fmt_mode))) ^ par_odd ^ bp);
      else
        put(d[i]);
      tk(16);
    end
    st  = (stop_sel == 2'b00) ? 8 : (stop_sel == 2'b01) ? 16 : (stop_sel == 2'b10) ? 24 : 32;
    seg = (stop_sel == 2'b00) ? 8 : 16;
    for (int i = 0; i < st; i++) begin
      put(!((bs && i >= seg / 4 && i < (3 * seg) / 4) || (bs2 && i >= 20 && i < 28)));
      tk(1);
    end
    put(1'b1);
  endtask

  task automatic frame(input logic [8:0] d, input bit bp, input bit bs, input bit bs2, input string tag);
    eq.push_back(model(fmt_mode, d, bp && is_par(fmt_mode), bs || (bs2 && stop_sel == 2'b11)));
    tq.push_back(tag);
    send(d, bp, bs, bs2);
  endtask

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      logic [10:0] e;
      string t;
      n_valid++;
      chk(!prev_v, "R13 pulse", 32'(prev_v), 32'd0);
      if (eq.size() == 0) begin
        chk(1'b0, "R2/R12 unexpected word", 32'({rx_break, rx_word}), 32'h0);
      end else begin
        e = eq.pop_front();
        t = tq.pop_front();
        chk({rx_break, rx_word} === e, t, 32'({rx_break, rx_word}), 32'(e));
      end
    end
    prev_v = rx_valid;
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd4711));
    repeat (6) @(negedge clk);
    chk(rx_valid == 1'b0 && rx_break == 1'b0 && rx_word == 10'd0, "R1 reset", 32'({rx_break, rx_valid, rx_word}), 32'd0);
    rst = 1'b0;
    tk(10);
    chk(rx_valid == 1'b0 && rx_word == 10'd0, "R1 idle", 32'(rx_word), 32'd0);

    cfg(3'b001, 2'b01, 1'b0); frame(9'h1A5, 0, 0, 0, "R3 8-bit"); tk(4);
    cfg(3'b000, 2'b01, 1'b0); frame(9'h13C, 0, 0, 0, "R3 unlisted code"); tk(4);
    cfg(3'b011, 2'b01, 1'b0); frame(9'h0D3, 0, 0, 0, "R4 7+p even ok"); tk(4);
    frame(9'h055, 1, 0, 0, "R4 R7 7+p even error"); tk(4);
    cfg(3'b011, 2'b01, 1'b1); frame(9'h055, 0, 0, 0, "R7 odd ok"); tk(4);
    frame(9'h02A, 1, 0, 0, "R7 odd error"); tk(4);
    cfg(3'b111, 2'b11, 1'b1); frame(9'h0F0, 1, 0, 0, "R5 8+p error"); tk(4);
    frame(9'h081, 0, 0, 0, "R5 8+p ok"); tk(4);
    cfg(3'b100, 2'b01, 1'b0); frame(9'h1A5, 0, 0, 0, "R6 9-bit"); tk(4);
    cfg(3'b101, 2'b10, 1'b0); frame(9'h100, 0, 0, 0, "R6 wake bit"); tk(4);
    cfg(3'b001, 2'b01, 1'b0); frame(9'h0C3, 0, 1, 0, "R8 stop low"); tk(4);
    cfg(3'b001, 2'b11, 1'b0); frame(9'h03C, 0, 0, 1, "R8 second stop low"); tk(4);

    for (int s = 0; s < 4; s++) begin
      cfg(3'b001, 2'(s), 1'b0);
      frame(9'h0A1, 0, 0, 0, "R9 back-to-back");
      frame(9'h05E, 0, 0, 0, "R9 back-to-back");
      frame(9'h0FF, 0, 0, 0, "R9 back-to-back");
      tk(6);
    end

    cfg(3'b001, 2'b01, 1'b0);
    eq.push_back({1'b1, 10'h200}); tq.push_back("R10 break");
    put(1'b0); tk(160); put(1'b1); tk(40);
    frame(9'h000, 0, 1, 0, "R10 zero data with stop error"); tk(4);
    frame(9'h010, 0, 1, 0, "R10 not a break"); tk(4);

    base = n_valid;
    put(1'b0); tk(3); put(1'b1); tk(40);
    chk(n_valid == base, "R2 false start", 32'(n_valid - base), 32'd0);

    rx_en = 1'b0; tk(2);
    send(9'h066, 0, 0, 0); tk(30);
    chk(n_valid == base, "R12 disabled", 32'(n_valid - base), 32'd0);
    rx_en = 1'b1; tk(4);
    frame(9'h099, 0, 0, 0, "R12 re-enabled"); tk(4);

    loop_en = 1'b1; rx_pin = 1'b0; tk(4);
    frame(9'h0B7, 0, 0, 0, "R11 loopback"); tk(10);
    rx_pin = 1'b1; tk(2); loop_en = 1'b0; tk(10);

    for (int k = 0; k < 150; k++) begin
      logic [2:0] m;
      bit bp, bs;
      m  = modes[$urandom % 5];
      cfg(m, 2'($urandom % 4), 1'($urandom % 2));
      bp = ($urandom % 5) == 0;
      bs = ($urandom % 6) == 0;
      frame(9'($urandom), bp, bs, 0, "R3-R8 random frame");
      tk(4 + int'($urandom % 12));
    end

    tk(60);
    chk(eq.size() == 0, "R13 all words seen", 32'(eq.size()), 32'd0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule